// File: doc/BRIEF.md
# Registered Bus Burst Initiator Sequencer

This block is the control engine an initiator uses to run a single burst on a registered, wide parallel bus. After a start request it drives an address cycle and then exactly one attribute cycle. The attribute cycle carries the requester identity, the byte count, a transaction tag and a few status bits. The block then waits for a target to claim the transaction. Claims are accepted up to and including the subtractive-decode slot, which lies two cycles past the slow-decode slot. Once the target is ready, the block streams the data beats back to back.

The burst length is fixed by the byte count when the request is accepted. The initiator never pauses a burst. It drops its frame signal ahead of the end so that the target sees the end coming. A target may stall only before the first beat, and for writes only by an even number of cycles. A target may also ask for a disconnect, but the request takes effect only where the next beat would start on a 128-byte boundary. In that case the unsent byte count is reported so the rest can be reissued. If no target claims the transaction, the block ends with a master-abort result.

Control and datapath are separate modules. The control module steps through the phases and sends a small set of strobes to the datapath. The datapath holds the request, the beat address, the beat count, the attribute word and the result registers.

Top module: `rbis_top`

## Requirements
- R1: In the first cycle after a start request is accepted in idle, the block drives the frame signal high, puts the low 32 bits of the start address on the address/data lines, and puts the command on the 4 command lines: 4'hE for a read, 4'hF for a write. Exactly one attribute cycle follows this address cycle.
- R2: In the attribute cycle, the address/data lines carry {id[15:0], byteCount[11:0], tag[3:0]} and the command lines carry {tag[4], status[2:0]}, with the frame signal still high.
- R3: The decode wait starts in the cycle after the attribute cycle, numbered 1. A target claim (devselIn high) seen in any decode cycle from 1 to 5 is accepted, and the target-wait phase starts in the next cycle.
- R4: If no claim arrives by decode cycle 5, the transaction ends with no data beat. In the next cycle done pulses with abortOut high and remainOut equal to the full byte count.
- R5: In target wait, a read starts its first beat in the cycle after trdyIn is seen high. A write leaves target wait only on a high trdyIn after an even number of wait cycles (0, 2, 4, ...).
- R6: The burst has byteCount/8 beats, and a count of 0 means 4096 bytes. irdyOut is high in every cycle from the first beat to the last. beatAddr starts at the start address and rises by 8 on each beat.
- R7: The frame signal stays high through all phases before the data. During the data it is high on a beat only while more than two beats, including the current one, remain in the full burst. A one-beat burst therefore has the frame low on its only beat.
- R8: stopIn is honoured on a beat only when the address after that beat has its bits [6:3] all zero (128-byte boundary). The burst then ends after that beat with discOut high and remainOut holding the unsent bytes. A stopIn on any other beat has no effect.
- R9: done pulses for exactly one cycle, in the cycle after the final beat, and busyOut is low in that cycle. After a full burst, abortOut and discOut are low and remainOut is 0.
- R10: After reset, busyOut, frameOut, irdyOut and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a transaction (accepted in idle) |
| reqRead | input | 1 | 1 read, 0 write |
| reqAddr | input | ADDR_W | Start byte address |
| reqByteCount | input | LEN_W | Byte count, 0 encodes 4096 |
| reqId | input | 16 | Requester identity |
| reqTag | input | 5 | Transaction tag |
| reqStatus | input | 3 | Extra attribute status bits |
| devselIn | input | 1 | Target claim |
| trdyIn | input | 1 | Target ready for first beat |
| stopIn | input | 1 | Target disconnect request |
| busyOut | output | 1 | Transaction in progress |
| frameOut | output | 1 | Frame signal, active high |
| irdyOut | output | 1 | Data beat in this cycle |
| adOut | output | 32 | Address/attribute lines |
| cbeOut | output | 4 | Command/attribute upper lines |
| beatAddr | output | ADDR_W | Byte address of the current beat |
| done | output | 1 | One-cycle end pulse |
| abortOut | output | 1 | Last transaction master-aborted |
| discOut | output | 1 | Last transaction was disconnected |
| remainOut | output | LEN_W+1 | Bytes not transferred |

## Verification
The hardest case to reach is a disconnect that the block must honour. stopIn has to be high on exactly the beat whose successor starts at a 128-byte boundary. That beat can lie deep inside the burst when the start address is not aligned. The directed test starts 64 bytes into a block and raises stopIn early. It then holds stopIn high over several beats that do not qualify, so the bench sees those beats ignored and the burst end right at the boundary. A second test holds stopIn high through a whole burst that never reaches a boundary. The subtractive-decode claim is reached by delaying devselIn to the last accepted slot. The write parity rule is reached by raising trdyIn after an odd number of wait cycles.

// File: rtl/rbis_pkg.sv
package rbis_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ATTR,
    PH_DECODE,
    PH_TWAIT,
    PH_DATA
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic driveAttr;
    logic framePre;
    logic stepBeat;
    logic endOk;
    logic endAbort;
    logic endDisc;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lastBeat;
    logic atBoundary;
    logic isRead;
  } dpStat_t;

  // 36-bit attribute word: upper nibble goes on the command lines
  function automatic logic [35:0] packAttr(input logic [15:0] id,
                                           input logic [11:0] cnt,
                                           input logic [4:0]  tag,
                                           input logic [2:0]  st);
    return {tag[4], st, id, cnt, tag[3:0]};
  endfunction

endpackage

// File: rtl/rbis_ctrl.sv
module rbis_ctrl
  import rbis_pkg::*;
#(
  parameter int SLOW_SLOT = 3,
  parameter int SUB_GAP   = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    devselIn,
  input  logic    trdyIn,
  input  logic    stopIn,
  input  dpStat_t dpStat,
  output strobe_t strobe,
  output phase_t  phaseNow
);

  localparam int SUB_SLOT = SLOW_SLOT + SUB_GAP;
  localparam int CNT_W    = $clog2(SUB_SLOT + 1);

  phase_t     stateQ, stateD;
  logic [CNT_W-1:0] decCnt;
  logic       twOdd;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      PH_IDLE: begin
        if (startReq) begin
          strobe.loadReq = 1'b1;
          stateD         = PH_ADDR;
        end
      end
      PH_ADDR: begin
        strobe.driveAddr = 1'b1;
        strobe.framePre  = 1'b1;
        stateD           = PH_ATTR;
      end
      PH_ATTR: begin
        strobe.driveAttr = 1'b1;
        strobe.framePre  = 1'b1;
        stateD           = PH_DECODE;
      end
      PH_DECODE: begin
        strobe.framePre = 1'b1;
        if (devselIn) begin
          stateD = PH_TWAIT;
        end else if (decCnt == CNT_W'(SUB_SLOT)) begin
          strobe.endAbort = 1'b1;
          stateD          = PH_IDLE;
        end
      end
      PH_TWAIT: begin
        strobe.framePre = 1'b1;
        if (trdyIn && (dpStat.isRead || !twOdd)) stateD = PH_DATA;
      end
      PH_DATA: begin
        strobe.stepBeat = 1'b1;
        if (dpStat.lastBeat) begin
          strobe.endOk = 1'b1;
          stateD       = PH_IDLE;
        end else if (stopIn && dpStat.atBoundary) begin
          strobe.endDisc = 1'b1;
          stateD         = PH_IDLE;
        end
      end
      default: stateD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= PH_IDLE;
      decCnt <= '0;
      twOdd  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == PH_ATTR)        decCnt <= CNT_W'(1);
      else if (stateQ == PH_DECODE) decCnt <= decCnt + 1'b1;
      if (stateQ == PH_TWAIT) twOdd <= ~twOdd;
      else                    twOdd <= 1'b0;
    end
  end

  assign phaseNow = stateQ;

endmodule

// File: rtl/rbis_dp.sv
module rbis_dp
  import rbis_pkg::*;
#(
  parameter int         ADDR_W      = 32,
  parameter int         LEN_W       = 12,
  parameter int         BOUND_BYTES = 128,
  parameter logic [3:0] CMD_RD      = 4'hE,
  parameter logic [3:0] CMD_WR      = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              reqRead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqByteCount,
  input  logic [15:0]       reqId,
  input  logic [4:0]        reqTag,
  input  logic [2:0]        reqStatus,
  output dpStat_t           dpStat,
  output logic              frameOut,
  output logic              irdyOut,
  output logic [31:0]       adOut,
  output logic [3:0]        cbeOut,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              done,
  output logic              abortOut,
  output logic              discOut,
  output logic [LEN_W:0]    remainOut
);

  localparam int BEAT_W = LEN_W - 2;
  localparam int BND_W  = $clog2(BOUND_BYTES);
  localparam logic [BEAT_W-1:0] MAX_BEATS = BEAT_W'(1) << (LEN_W - 3);
  localparam logic [LEN_W:0]    FULL_LEN  = (LEN_W+1)'(1) << LEN_W;

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  cntQ;
  logic [15:0]       idQ;
  logic [4:0]        tagQ;
  logic [2:0]        stQ;
  logic              readQ;
  logic [BEAT_W-1:0] beatsLeft;
  logic [35:0]       attrWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      cntQ      <= '0;
      idQ       <= '0;
      tagQ      <= '0;
      stQ       <= '0;
      readQ     <= 1'b0;
      beatsLeft <= '0;
      done      <= 1'b0;
      abortOut  <= 1'b0;
      discOut   <= 1'b0;
      remainOut <= '0;
    end else begin
      done <= strobe.endOk | strobe.endAbort | strobe.endDisc;
      if (strobe.loadReq) begin
        curAddr   <= reqAddr;
        cntQ      <= reqByteCount;
        idQ       <= reqId;
        tagQ      <= reqTag;
        stQ       <= reqStatus;
        readQ     <= reqRead;
        beatsLeft <= (reqByteCount[LEN_W-1:3] == '0) ? MAX_BEATS
                                                     : BEAT_W'(reqByteCount[LEN_W-1:3]);
        abortOut  <= 1'b0;
        discOut   <= 1'b0;
        remainOut <= '0;
      end
      if (strobe.stepBeat) begin
        curAddr   <= curAddr + ADDR_W'(8);
        beatsLeft <= beatsLeft - 1'b1;
      end
      if (strobe.endAbort) begin
        abortOut  <= 1'b1;
        remainOut <= (cntQ == '0) ? FULL_LEN : (LEN_W+1)'(cntQ);
      end
      if (strobe.endDisc) begin
        discOut   <= 1'b1;
        remainOut <= {beatsLeft - 1'b1, 3'b000};
      end
      if (strobe.endOk) remainOut <= '0;
    end
  end

  assign attrWord = packAttr(idQ, cntQ, tagQ, stQ);

  always_comb begin
    adOut  = '0;
    cbeOut = '0;
    if (strobe.driveAddr) begin
      adOut  = curAddr[31:0];
      cbeOut = readQ ? CMD_RD : CMD_WR;
    end else if (strobe.driveAttr) begin
      adOut  = attrWord[31:0];
      cbeOut = attrWord[35:32];
    end
  end

  assign frameOut = strobe.framePre | (strobe.stepBeat && beatsLeft > BEAT_W'(2));
  assign irdyOut  = strobe.stepBeat;
  assign beatAddr = curAddr;

  assign dpStat.lastBeat   = (beatsLeft == BEAT_W'(1));
  assign dpStat.atBoundary = &curAddr[BND_W-1:3];
  assign dpStat.isRead     = readQ;

endmodule

// File: rtl/rbis_top.sv
module rbis_top
  import rbis_pkg::*;
#(
  parameter int         ADDR_W      = 32,
  parameter int         LEN_W       = 12,
  parameter int         SLOW_SLOT   = 3,
  parameter int         SUB_GAP     = 2,
  parameter int         BOUND_BYTES = 128,
  parameter logic [3:0] CMD_RD      = 4'hE,
  parameter logic [3:0] CMD_WR      = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              reqRead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqByteCount,
  input  logic [15:0]       reqId,
  input  logic [4:0]        reqTag,
  input  logic [2:0]        reqStatus,
  input  logic              devselIn,
  input  logic              trdyIn,
  input  logic              stopIn,
  output logic              busyOut,
  output logic              frameOut,
  output logic              irdyOut,
  output logic [31:0]       adOut,
  output logic [3:0]        cbeOut,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              done,
  output logic              abortOut,
  output logic              discOut,
  output logic [LEN_W:0]    remainOut
);

  strobe_t strobe;
  dpStat_t dpStat;
  phase_t  phaseNow;

  rbis_ctrl #(
    .SLOW_SLOT(SLOW_SLOT),
    .SUB_GAP  (SUB_GAP)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .devselIn(devselIn),
    .trdyIn  (trdyIn),
    .stopIn  (stopIn),
    .dpStat  (dpStat),
    .strobe  (strobe),
    .phaseNow(phaseNow)
  );

  rbis_dp #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .BOUND_BYTES(BOUND_BYTES),
    .CMD_RD     (CMD_RD),
    .CMD_WR     (CMD_WR)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqRead     (reqRead),
    .reqAddr     (reqAddr),
    .reqByteCount(reqByteCount),
    .reqId       (reqId),
    .reqTag      (reqTag),
    .reqStatus   (reqStatus),
    .dpStat      (dpStat),
    .frameOut    (frameOut),
    .irdyOut     (irdyOut),
    .adOut       (adOut),
    .cbeOut      (cbeOut),
    .beatAddr    (beatAddr),
    .done        (done),
    .abortOut    (abortOut),
    .discOut     (discOut),
    .remainOut   (remainOut)
  );

  assign busyOut = (phaseNow != PH_IDLE);

endmodule

// File: rtl/rbis_checker.sv
module rbis_checker
  import rbis_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SLOW_SLOT   = 3,
  parameter int SUB_GAP     = 2,
  parameter int BOUND_BYTES = 128
) (
  input logic              clk,
  input logic              rstN,
  input phase_t            phaseNow,
  input logic              frameOut,
  input logic              irdyOut,
  input logic              done,
  input logic              abortOut,
  input logic              discOut,
  input logic [ADDR_W-1:0] beatAddr
);

  localparam int SUB_SLOT = SLOW_SLOT + SUB_GAP;
  localparam int BND_W    = $clog2(BOUND_BYTES);

  int decSeen;
  always_ff @(posedge clk) begin
    if (!rstN)                     decSeen <= 0;
    else if (phaseNow == PH_DECODE) decSeen <= decSeen + 1;
    else                           decSeen <= 0;
  end

  // R1: one attribute cycle right after the address cycle
  p_attr_after_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    phaseNow == PH_ADDR |=> phaseNow == PH_ATTR);

  // R4: decode wait never exceeds the subtractive slot
  p_decode_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    phaseNow == PH_DECODE |-> decSeen < SUB_SLOT);

  // R6: no initiator gap inside a burst
  p_no_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irdyOut) |-> phaseNow == PH_IDLE);

  // R7: once frame drops during data it stays low
  p_frame_stays_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irdyOut && !frameOut) |=> !frameOut);

  // R8: a disconnect leaves the beat address on a boundary
  p_disc_aligned_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && discOut) |-> beatAddr[BND_W-1:0] == '0);

  // R9: at most one end cause, done only in idle
  p_one_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones({abortOut, discOut}) <= 1 && phaseNow == PH_IDLE));

endmodule

bind rbis_top rbis_checker #(
  .ADDR_W     (ADDR_W),
  .SLOW_SLOT  (SLOW_SLOT),
  .SUB_GAP    (SUB_GAP),
  .BOUND_BYTES(BOUND_BYTES)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .phaseNow(phaseNow),
  .frameOut(frameOut),
  .irdyOut (irdyOut),
  .done    (done),
  .abortOut(abortOut),
  .discOut (discOut),
  .beatAddr(beatAddr)
);

// File: tb/test_rbis_top.sv
module test_rbis_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, reqRead = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [11:0] reqByteCount = '0;
  logic [15:0] reqId = '0;
  logic [4:0]  reqTag = '0;
  logic [2:0]  reqStatus = '0;
  logic        devselIn = 1'b0, trdyIn = 1'b0, stopIn = 1'b0;
  logic        busyOut, frameOut, irdyOut, done, abortOut, discOut;
  logic [31:0] adOut, beatAddr;
  logic [3:0]  cbeOut;
  logic [12:0] remainOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rbis_top i_rbis_top (
    .clk(clk), .rstN(rstN), .startReq(startReq), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqByteCount(reqByteCount), .reqId(reqId),
    .reqTag(reqTag), .reqStatus(reqStatus), .devselIn(devselIn),
    .trdyIn(trdyIn), .stopIn(stopIn), .busyOut(busyOut),
    .frameOut(frameOut), .irdyOut(irdyOut), .adOut(adOut), .cbeOut(cbeOut),
    .beatAddr(beatAddr), .done(done), .abortOut(abortOut),
    .discOut(discOut), .remainOut(remainOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // devDelay: decode cycle of the claim (0 = never); trdyDelay: wait cycles
  // before trdy rises; stopBeat: beat index from which stop is held (-1 none)
  task automatic runTxn(input bit isRd, input logic [31:0] addr, input logic [11:0] cnt,
                        input logic [15:0] id, input logic [4:0] tag, input logic [2:0] st,
                        input int devDelay, input int trdyDelay, input int stopBeat);
    logic [35:0] expAttr = {tag[4], st, id, cnt, tag[3:0]};
    int  total = (cnt[11:3] == 0) ? 512 : int'(cnt[11:3]);
    int  expBeats = total;
    bit  expDisc = 1'b0;
    int  twStart = 3 + devDelay;
    int  firstExp;
    int  k = 0;
    int  firstSeen = -1;
    int  doneCyc = -1;
    bit  gapErr = 1'b0;
    bit  frameErr = 1'b0;
    bit  addrErr = 1'b0;
    if (isRd) firstExp = twStart + trdyDelay + 1;
    else      firstExp = twStart + ((trdyDelay % 2 == 0) ? trdyDelay : trdyDelay + 1) + 1;
    if (stopBeat >= 0) begin
      for (int j = stopBeat; j < total; j++) begin
        if (j == total - 1) break;
        if (((addr + 32'(8*j)) & 32'h78) == 32'h78) begin
          expBeats = j + 1;
          expDisc  = 1'b1;
          break;
        end
      end
    end
    @(negedge clk);
    startReq = 1'b1; reqRead = isRd; reqAddr = addr; reqByteCount = cnt;
    reqId = id; reqTag = tag; reqStatus = st;
    for (int cyc = 1; cyc < 800; cyc++) begin
      @(negedge clk);
      startReq = 1'b0;
      if (cyc == 1) begin
        check(frameOut == 1'b1, "R1 addr frame", frameOut, 1);
        check(adOut == addr, "R1 addr lines", adOut, addr);
        check(cbeOut == (isRd ? 4'hE : 4'hF), "R1 command", cbeOut, isRd ? 4'hE : 4'hF);
      end
      if (cyc == 2) begin
        check(adOut == expAttr[31:0], "R2 attr low", adOut, expAttr[31:0]);
        check(cbeOut == expAttr[35:32], "R2 attr high", cbeOut, expAttr[35:32]);
        check(frameOut == 1'b1, "R1 attr frame", frameOut, 1);
      end
      if (done) begin doneCyc = cyc; break; end
      if (irdyOut) begin
        if (firstSeen < 0) firstSeen = cyc;
        if (beatAddr != addr + 32'(8*k)) addrErr = 1'b1;
        if (frameOut != (total - k > 2)) frameErr = 1'b1;
        stopIn = (stopBeat >= 0) && (k >= stopBeat);
        k++;
      end else begin
        if (firstSeen >= 0) gapErr = 1'b1;
        stopIn = 1'b0;
        if (cyc > 2 && firstSeen < 0 && !frameOut) frameErr = 1'b1;
      end
      devselIn = (devDelay > 0) && (cyc == 2 + devDelay);
      trdyIn   = (devDelay > 0) && (cyc >= twStart + trdyDelay);
    end
    devselIn = 1'b0; trdyIn = 1'b0; stopIn = 1'b0;
    if (devDelay == 0) begin
      check(doneCyc == 8, "R4 abort timing", doneCyc, 8);
      check(k == 0, "R4 no beats", k, 0);
      check(abortOut == 1'b1, "R4 abort flag", abortOut, 1);
      check(remainOut == 13'(total * 8), "R4 remain", remainOut, total * 8);
    end else begin
      check(firstSeen == firstExp, "R3 R5 first beat cycle", firstSeen, firstExp);
      check(k == expBeats, "R6 R8 beat count", k, expBeats);
      check(!gapErr && !addrErr, "R6 beats consecutive and addressed", {gapErr, addrErr}, 0);
      check(!frameErr, "R7 frame timing", frameErr, 0);
      check(doneCyc == firstSeen + expBeats, "R9 done timing", doneCyc, firstSeen + expBeats);
      check(discOut == expDisc, "R8 disconnect flag", discOut, expDisc);
      check(abortOut == 1'b0, "R9 no abort", abortOut, 0);
      check(remainOut == 13'((total - expBeats) * 8), "R8 R9 remain", remainOut,
            (total - expBeats) * 8);
    end
    check(busyOut == 1'b0, "R9 idle at done", busyOut, 0);
    @(negedge clk);
    check(done == 1'b0, "R9 single pulse", done, 0);
  endtask

  task automatic testReset();
    check(!busyOut && !frameOut && !irdyOut && !done, "R10 reset state",
          {busyOut, frameOut, irdyOut, done}, 0);
  endtask

  task automatic testReadBasic();     runTxn(1, 32'h0000_1000, 12'd64, 16'hA5C3, 5'h13, 3'h5, 1, 0, -1); endtask
  task automatic testWriteOddWait();  runTxn(0, 32'h0000_2008, 12'd32, 16'h1234, 5'h0A, 3'h2, 3, 1, -1); endtask
  task automatic testWriteEvenWait(); runTxn(0, 32'h0000_3000, 12'd24, 16'hFFFF, 5'h1F, 3'h7, 2, 2, -1); endtask
  task automatic testSingleBeat();    runTxn(1, 32'h0000_4010, 12'd8, 16'h0001, 5'h01, 3'h0, 1, 0, -1); endtask
  task automatic testAbort();         runTxn(1, 32'h0000_5000, 12'd40, 16'h0F0F, 5'h05, 3'h1, 0, 0, -1); endtask
  task automatic testSubtractive();   runTxn(1, 32'h0000_6000, 12'd16, 16'h8001, 5'h10, 3'h4, 5, 3, -1); endtask
  task automatic testDisconnect();    runTxn(1, 32'h1000_0040, 12'd256, 16'h2222, 5'h02, 3'h3, 2, 0, 1); endtask
  task automatic testStopIgnored();   runTxn(0, 32'h0000_7000, 12'd48, 16'h3333, 5'h03, 3'h6, 1, 0, 0); endtask
  task automatic testMaxLength();     runTxn(1, 32'h0001_0000, 12'd0, 16'h4444, 5'h04, 3'h0, 1, 0, -1); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadBasic();
    testWriteOddWait();
    testWriteEvenWait();
    testSingleBeat();
    testAbort();
    testSubtractive();
    testDisconnect();
    testStopIgnored();
    testMaxLength();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule